// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a conditional jump in a small sequencer core is taken. Each cycle it receives two 16-bit operands, a 5-bit condition code, a shift amount and a field width for the field tests, and a 64-line vector of external event conditions with an 8-bit selector. From these it produces one decision bit, `taken_o`, which is registered and appears one clock after the inputs were presented.

The condition set covers equality, signed and unsigned magnitude ordering, two bit-test forms (any common bit, and all bits of a pattern present), a field test that right-shifts operand A and masks it to a chosen number of low bits, and a test of one selected external line. Every condition has an inverse, encoded by bit 0 of the code. Target address arithmetic, program counter update and instruction decode are the job of neighbouring logic.

Top module: `bce_branch_eval`

## Requirements
- R1: While `rst_ni` is low, `taken_o` is 0.
- R2: `taken_o` shows the decision for the inputs sampled at the previous rising clock edge; a new condition may be presented every cycle.
- R3: Code 0 is taken when A equals B; code 1 is taken when they differ.
- R4: Code 2 is taken when A AND B is nonzero; code 3 is taken when A AND B is zero.
- R5: Code 4 is taken when every bit set in B is also set in A; code 5 is taken when at least one bit of B is clear in A.
- R6: Codes 6, 7, 8 and 9 are taken for A<B, A>=B, A>B and A<=B with both operands read as 16-bit two's complement.
- R7: Codes 10, 11, 12 and 13 are taken for A<B, A>=B, A>B and A<=B with both operands read as unsigned.
- R8: For codes 14 and 15 the field is (A shifted right by the shift input) masked to its low (width input + 1) bits, shift and width each 0 to 15; code 14 is taken when the field is zero, code 15 when it is nonzero.
- R9: Code 16 is taken when the external line numbered by the selector value (0 to 63, for example 0x24 picks line 36) is 1; code 17 is taken when that line is 0.
- R10: A selector value of 64 or more makes the external condition false: code 16 is then not taken and code 17 is taken, whatever the external lines hold.
- R11: Codes 18 to 31 are never taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| op_a_i | input | 16 | First operand; also the source of the field test |
| op_b_i | input | 16 | Second operand |
| cond_i | input | 5 | Condition code; bit 0 selects the inverse form |
| fld_shift_i | input | 4 | Right-shift amount for the field test |
| fld_width_i | input | 4 | Field width minus one for the field test |
| ext_sel_i | input | 8 | External line selector |
| ext_vec_i | input | 64 | External condition lines |
| taken_o | output | 1 | Registered jump decision |

## Verification
The evaluation of a new condition and the presentation of the previous decision share every cycle, so the bench changes the code, operands and external lines on every clock and checks that `taken_o` always carries the verdict of the preceding inputs, never a mix. Within one cycle the signed and unsigned orderings are computed on the same operands; stimulus with differing sign bits makes them disagree, and a behavioural model built on integer arithmetic judges which one the selected code must follow.

// File: rtl/bce_pkg.sv
package bce_pkg;

    localparam int COND_W = 5;

    typedef enum logic [COND_W-1:0] {
        C_EQ       = 5'd0,
        C_NE       = 5'd1,
        C_ANY      = 5'd2,
        C_NONE     = 5'd3,
        C_ALLSET   = 5'd4,
        C_NALLSET  = 5'd5,
        C_LTS      = 5'd6,
        C_GES      = 5'd7,
        C_GTS      = 5'd8,
        C_LES      = 5'd9,
        C_LTU      = 5'd10,
        C_GEU      = 5'd11,
        C_GTU      = 5'd12,
        C_LEU      = 5'd13,
        C_FZERO    = 5'd14,
        C_FNZERO   = 5'd15,
        C_EXT_T    = 5'd16,
        C_EXT_F    = 5'd17
    } cond_e;

    // Condition pair index: code with the inverse bit dropped.
    typedef enum logic [COND_W-2:0] {
        P_EQ     = 4'd0,
        P_ANY    = 4'd1,
        P_ALLSET = 4'd2,
        P_LTS    = 4'd3,
        P_GTS    = 4'd4,
        P_LTU    = 4'd5,
        P_GTU    = 4'd6,
        P_FZERO  = 4'd7,
        P_EXT    = 4'd8
    } pair_e;

    typedef struct packed {
        logic taken;
    } dec_st_t;

endpackage

// File: rtl/bce_compare.sv
module bce_compare #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic              eq_o,
    output logic              lt_s_o,
    output logic              lt_u_o,
    output logic              gt_s_o,
    output logic              gt_u_o
);
    always_comb begin
        eq_o   = (a_i == b_i);
        lt_u_o = (a_i < b_i);
        gt_u_o = (a_i > b_i);
        lt_s_o = ($signed(a_i) < $signed(b_i));
        gt_s_o = ($signed(a_i) > $signed(b_i));
    end
endmodule

// File: rtl/bce_bittest.sv
module bce_bittest #(
    parameter int DATA_W  = 16,
    parameter int SHIFT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]  a_i,
    input  logic [DATA_W-1:0]  b_i,
    input  logic [SHIFT_W-1:0] shift_i,
    input  logic [SHIFT_W-1:0] width_i,
    output logic               any_o,
    output logic               allset_o,
    output logic               fzero_o
);
    logic [DATA_W-1:0] common;
    logic [DATA_W-1:0] keep_mask;
    logic [DATA_W-1:0] shifted;

    // Field mask: bit i kept when i <= width, so width+1 low bits survive.
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_mask
        assign keep_mask[gi] = (width_i >= SHIFT_W'(gi));
    end

    always_comb begin
        common   = a_i & b_i;
        any_o    = |common;
        allset_o = (common == b_i);
        shifted  = a_i >> shift_i;
        fzero_o  = ~|(shifted & keep_mask);
    end
endmodule

// File: rtl/bce_extsel.sv
module bce_extsel #(
    parameter int EXT_N = 64,
    parameter int SEL_W = 8
) (
    input  logic [SEL_W-1:0] sel_i,
    input  logic [EXT_N-1:0] vec_i,
    output logic             hit_o
);
    localparam int IDX_W = $clog2(EXT_N);

    logic             in_range;
    logic [IDX_W-1:0] idx;

    generate
        if (SEL_W > IDX_W) begin : g_wide
            assign in_range = (sel_i < SEL_W'(EXT_N));
            assign idx      = sel_i[IDX_W-1:0];
        end else begin : g_narrow
            assign in_range = (IDX_W'(sel_i) < IDX_W'(EXT_N - 1)) ||
                              (IDX_W'(sel_i) == IDX_W'(EXT_N - 1));
            assign idx      = IDX_W'(sel_i);
        end
    endgenerate

    always_comb begin
        hit_o = 1'b0;
        for (int k = 0; k < EXT_N; k++) begin
            if (in_range && (idx == IDX_W'(k))) hit_o = vec_i[k];
        end
    end
endmodule

// File: rtl/bce_branch_eval.sv
module bce_branch_eval
    import bce_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int EXT_N   = 64,
    parameter int SEL_W   = 8,
    parameter int SHIFT_W = $clog2(DATA_W)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [DATA_W-1:0]    op_a_i,
    input  logic [DATA_W-1:0]    op_b_i,
    input  logic [COND_W-1:0]    cond_i,
    input  logic [SHIFT_W-1:0]   fld_shift_i,
    input  logic [SHIFT_W-1:0]   fld_width_i,
    input  logic [SEL_W-1:0]     ext_sel_i,
    input  logic [EXT_N-1:0]     ext_vec_i,
    output logic                 taken_o
);
    logic eq, lt_s, lt_u, gt_s, gt_u;
    logic any, allset, fzero, ext_hit;
    logic base;
    logic invert;
    pair_e pair;

    dec_st_t st_d, st_q;

    bce_compare #(.DATA_W(DATA_W)) u_cmp (
        .a_i    (op_a_i),
        .b_i    (op_b_i),
        .eq_o   (eq),
        .lt_s_o (lt_s),
        .lt_u_o (lt_u),
        .gt_s_o (gt_s),
        .gt_u_o (gt_u)
    );

    bce_bittest #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_bit (
        .a_i      (op_a_i),
        .b_i      (op_b_i),
        .shift_i  (fld_shift_i),
        .width_i  (fld_width_i),
        .any_o    (any),
        .allset_o (allset),
        .fzero_o  (fzero)
    );

    bce_extsel #(.EXT_N(EXT_N), .SEL_W(SEL_W)) u_ext (
        .sel_i (ext_sel_i),
        .vec_i (ext_vec_i),
        .hit_o (ext_hit)
    );

    always_comb begin
        pair   = pair_e'(cond_i[COND_W-1:1]);
        invert = cond_i[0];
        base   = 1'b0;
        unique case (pair)
            P_EQ:     base = eq;
            P_ANY:    base = any;
            P_ALLSET: base = allset;
            P_LTS:    base = lt_s;
            P_GTS:    base = gt_s;
            P_LTU:    base = lt_u;
            P_GTU:    base = gt_u;
            P_FZERO:  base = fzero;
            P_EXT:    base = ext_hit;
            default:  base = 1'b0;
        endcase
        // Pairs 3..6: inverse of "less" is ">=" and of "greater" is "<=".
        st_d.taken = 1'b0;
        if (cond_i <= COND_W'(C_EXT_F)) st_d.taken = base ^ invert;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign taken_o = st_q.taken;

endmodule

// File: rtl/bce_branch_eval_chk.sv
module bce_branch_eval_chk
    import bce_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int EXT_N   = 64,
    parameter int SEL_W   = 8,
    parameter int SHIFT_W = $clog2(DATA_W)
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [DATA_W-1:0]  op_a_i,
    input logic [DATA_W-1:0]  op_b_i,
    input logic [COND_W-1:0]  cond_i,
    input logic [SEL_W-1:0]   ext_sel_i,
    input logic               taken_o
);
    // R1
    a_r1_reset_low: assert property (@(posedge clk_i)
        !rst_ni |=> !taken_o);

    // R3
    a_r3_eq_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cond_i == C_EQ && op_a_i == op_b_i) |=> taken_o);

    a_r3_ne_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cond_i == C_NE && op_a_i != op_b_i) |=> taken_o);

    // R5
    a_r5_allset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cond_i == C_ALLSET && ((op_a_i & op_b_i) == op_b_i)) |=> taken_o);

    // R6
    a_r6_lts_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cond_i == C_LTS && op_a_i[DATA_W-1] && !op_b_i[DATA_W-1]) |=> taken_o);

    // R7
    a_r7_ltu_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cond_i == C_LTU && op_a_i[DATA_W-1] && !op_b_i[DATA_W-1]) |=> !taken_o);

    // R10
    a_r10_ext_oob_true: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cond_i == C_EXT_T && ext_sel_i >= SEL_W'(EXT_N)) |=> !taken_o);

    a_r10_ext_oob_false: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cond_i == C_EXT_F && ext_sel_i >= SEL_W'(EXT_N)) |=> taken_o);

    // R11
    a_r11_unused_codes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cond_i > COND_W'(C_EXT_F)) |=> !taken_o);

endmodule

bind bce_branch_eval bce_branch_eval_chk #(
    .DATA_W (DATA_W),
    .EXT_N  (EXT_N),
    .SEL_W  (SEL_W),
    .SHIFT_W(SHIFT_W)
) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_a_i    (op_a_i),
    .op_b_i    (op_b_i),
    .cond_i    (cond_i),
    .ext_sel_i (ext_sel_i),
    .taken_o   (taken_o)
);

// File: tb/bce_branch_eval_tb_top.sv
`timescale 1ns/1ps
module bce_branch_eval_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic [4:0]  cond = '0;
    logic [3:0]  fsh = '0;
    logic [3:0]  fw = '0;
    logic [7:0]  sel = '0;
    logic [63:0] vec = '0;
    logic        taken;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Pending expectation for the inputs driven in the previous cycle (R2).
    bit    pend = 0;
    bit    pend_exp;
    string pend_req;
    int    pend_cond;

    always #5 clk = ~clk;

    bce_branch_eval dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .op_a_i      (op_a),
        .op_b_i      (op_b),
        .cond_i      (cond),
        .fld_shift_i (fsh),
        .fld_width_i (fw),
        .ext_sel_i   (sel),
        .ext_vec_i   (vec),
        .taken_o     (taken)
    );

    function automatic bit ref_taken(int c, logic [15:0] a, logic [15:0] b,
                                     int sh, int w, int s, logic [63:0] v);
        int sa = $signed(a);
        int sb = $signed(b);
        int ua = a;
        int ub = b;
        int f;
        case (c)
            0:  return ua == ub;
            1:  return ua != ub;
            2:  return (a & b) != 16'd0;
            3:  return (a & b) == 16'd0;
            4:  return (a & b) == b;
            5:  return (a & b) != b;
            6:  return sa < sb;
            7:  return sa >= sb;
            8:  return sa > sb;
            9:  return sa <= sb;
            10: return ua < ub;
            11: return ua >= ub;
            12: return ua > ub;
            13: return ua <= ub;
            14, 15: begin
                f = (ua >> sh) % (1 << (w + 1));
                return (c == 14) ? (f == 0) : (f != 0);
            end
            16: return (s < 64) ? v[s] : 1'b0;
            17: return (s < 64) ? !v[s] : 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string req_of(int c, int s);
        if (c <= 1)  return "R3";
        if (c <= 3)  return "R4";
        if (c <= 5)  return "R5";
        if (c <= 9)  return "R6";
        if (c <= 13) return "R7";
        if (c <= 15) return "R8";
        if (c <= 17) return (s < 64) ? "R9" : "R10";
        return "R11";
    endfunction

    task automatic check_pending();
        if (pend) begin
            checks++;
            if (taken !== pend_exp) begin
                failures++;
                $display("FAIL %s (R2 one-cycle result) code=%0d actual=%b expected=%b",
                         pend_req, pend_cond, taken, pend_exp);
            end
        end
    endtask

    task automatic apply(int c, logic [15:0] a, logic [15:0] b,
                         int sh, int w, int s, logic [63:0] v);
        @(negedge clk);
        check_pending();
        cond = 5'(c); op_a = a; op_b = b;
        fsh = 4'(sh); fw = 4'(w); sel = 8'(s); vec = v;
        pend      = 1;
        pend_exp  = ref_taken(c, a, b, sh, w, s, v);
        pend_req  = req_of(c, s);
        pend_cond = c;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: inputs that would be taken, reset held low.
        cond = 5'd0; op_a = 16'h1234; op_b = 16'h1234;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            checks++;
            if (taken !== 1'b0) begin
                failures++;
                $display("FAIL R1 reset actual=%b expected=0", taken);
            end
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R3
        apply(0, 16'hBEEF, 16'hBEEF, 0, 0, 0, '0);
        apply(0, 16'hBEEF, 16'hBEEE, 0, 0, 0, '0);
        apply(1, 16'h0000, 16'h0001, 0, 0, 0, '0);
        apply(1, 16'h7777, 16'h7777, 0, 0, 0, '0);
        // R4
        apply(2, 16'h0100, 16'h0300, 0, 0, 0, '0);
        apply(2, 16'h00F0, 16'h0F0F, 0, 0, 0, '0);
        apply(3, 16'h00F0, 16'h0F0F, 0, 0, 0, '0);
        apply(3, 16'h8000, 16'h8000, 0, 0, 0, '0);
        // R5
        apply(4, 16'hFF0F, 16'h0F0F, 0, 0, 0, '0);
        apply(4, 16'hFF0F, 16'h0F1F, 0, 0, 0, '0);
        apply(4, 16'h1234, 16'h0000, 0, 0, 0, '0);
        apply(5, 16'h0003, 16'h0007, 0, 0, 0, '0);
        // R6 / R7 with differing sign bits
        apply(6,  16'h8000, 16'h0001, 0, 0, 0, '0);
        apply(10, 16'h8000, 16'h0001, 0, 0, 0, '0);
        apply(7,  16'hFFFF, 16'hFFFF, 0, 0, 0, '0);
        apply(8,  16'h7FFF, 16'h8000, 0, 0, 0, '0);
        apply(12, 16'h7FFF, 16'h8000, 0, 0, 0, '0);
        apply(9,  16'hFFFE, 16'hFFFF, 0, 0, 0, '0);
        apply(11, 16'h0005, 16'h0005, 0, 0, 0, '0);
        apply(13, 16'hFFFF, 16'h0000, 0, 0, 0, '0);
        // R8
        apply(14, 16'h0380, 16'h0, 7, 2, 0, '0);
        apply(14, 16'h0380, 16'h0, 10, 5, 0, '0);
        apply(15, 16'h8000, 16'h0, 15, 0, 0, '0);
        apply(15, 16'h8000, 16'h0, 0, 14, 0, '0);
        apply(14, 16'h8000, 16'h0, 0, 15, 0, '0);
        // R9 / R10
        apply(16, 16'h0, 16'h0, 0, 0, 8'h24, 64'h0000_0010_0000_0000);
        apply(16, 16'h0, 16'h0, 0, 0, 8'h24, 64'hFFFF_FFEF_FFFF_FFFF);
        apply(17, 16'h0, 16'h0, 0, 0, 63, 64'h7FFF_FFFF_FFFF_FFFF);
        apply(16, 16'h0, 16'h0, 0, 0, 0, 64'h1);
        apply(16, 16'h0, 16'h0, 0, 0, 64, '1);
        apply(17, 16'h0, 16'h0, 0, 0, 8'hC4, '1);
        // R11
        apply(18, 16'h1, 16'h1, 0, 0, 0, '1);
        apply(31, 16'h0, 16'h0, 0, 0, 0, '1);

        // Mixed back-to-back stimulus (R2 and all codes).
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] ra, rb;
            ra = 16'($urandom);
            rb = 16'($urandom);
            if (i % 5 == 0) rb = ra;
            if (i % 7 == 0) ra = ra | rb;
            apply(int'($urandom_range(0, 31)), ra, rb,
                  int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
                  int'($urandom_range(0, 127)),
                  {32'($urandom), 32'($urandom)});
        end
        @(negedge clk);
        check_pending();
        pend = 0;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule